// File: doc/BRIEF.md
# Power-Up Strap Capture and Frequency Code Selector

This block owns the pins of a clock generator that do double duty: during power-up they are read as configuration straps, and afterwards they carry clocks. Six such pins are handled. Five of them form a 5-bit frequency code. The sixth chooses the divide ratio of the super-I/O clock. After reset, a power-up timer keeps the pad drivers off. On the last clock of its interval it captures the synchronized strap levels. On the next edge it enables the pad drivers. From then on the straps are never read again until the next reset.

Once the straps are captured, the block decides which frequency code is active. By default that is the strapped code. When an override bit is set in the control byte coming from the serial configuration registers, the code is taken from selection bits in that byte instead. The active code is decoded into a spread-spectrum mode, either off, center spread or down spread. Each change of the active code is flagged with a one-cycle retune pulse to the clock synthesizer, which lies outside this block. A test bit in the control byte requests that every output be put into high impedance.

Top module: `strap_freq_select`

## Requirements
- R1: While reset is asserted and right after it, `pad_oe_o`, `straps_valid_o`, `retune_o` and `freq_code_o` are all 0, and `spread_o` is 2'b00 (off).
- R2: After reset is released, `straps_valid_o` and `pad_oe_o` stay 0 for POWERUP_CYCLES clock edges. Both rise at edge number POWERUP_CYCLES and stay high until reset.
- R3: The strap levels are captured only at the edge where `straps_valid_o` rises. Any later change on `strap_pad_i` does not affect `freq_code_o` or `sio_24m_o`.
- R4: `strap_pad_i[5]` is the super-I/O strap. `sio_24m_o` is 1 (24 MHz) when it was captured high and 0 (48 MHz) when it was captured low.
- R5: One edge after `straps_valid_o` rises, and on every edge after that, `freq_code_o` loads the selected code. When `ctl_i[3]` is 1, the code is {`ctl_i[2]`, `ctl_i[7:4]`}, with `ctl_i[2]` as bit 4. Otherwise it is the captured `strap_pad_i[4:0]`.
- R6: Codes 01100, 01101, 01110 and 01111 give `spread_o` = 2'b01 (center spread, +/-0.45%).
- R7: Codes 00001, 10011, 10101 and 11100 to 11111 give `spread_o` = 2'b10 (down spread, -0.6%). Every other code gives 2'b00 (off).
- R8: `test_hiz_o` follows `ctl_i[0]` combinationally. While it is 1, `pad_oe_o` is 0 even after the straps are valid.
- R9: `retune_o` is 1 for exactly the cycle in which `freq_code_o` shows a value different from its previous one. Rewriting the same code raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pad_i | input | 6 | Pad levels: [4:0] frequency code strap, [5] super-I/O strap |
| ctl_i | input | 8 | Control byte: [0] test hi-Z, [2] override code bit 4, [3] override enable, [7:4] override code bits 3..0 |
| pad_oe_o | output | 1 | Enables the strap pins as clock outputs |
| straps_valid_o | output | 1 | The straps have been captured |
| freq_code_o | output | 5 | Active frequency code |
| spread_o | output | 2 | Spread mode: 00 off, 01 center, 10 down |
| sio_24m_o | output | 1 | 1 selects 24 MHz, 0 selects 48 MHz for super-I/O |
| test_hiz_o | output | 1 | Requests high impedance on all outputs |
| retune_o | output | 1 | One-cycle pulse on a change of the active code |

## Verification
The assertions assume that `ctl_i` is synchronous to `clk`. They also assume that the strap pads are already stable for more than SYNC_STAGES cycles before the power-up interval ends. The checker counts cycles since reset on its own, so it can catch an early enable without a deep `$past`. The stimulus sets the strap levels while reset is asserted and changes `ctl_i` only on falling edges. It moves the pads only after capture, and only to show that such a change is ignored.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   localparam int CODE_W  = 5;
   localparam int STRAP_W = CODE_W + 1;

   typedef logic [CODE_W-1:0] fcode_t;

   typedef enum logic [1:0] {
      SPREAD_OFF    = 2'b00,
      SPREAD_CENTER = 2'b01,
      SPREAD_DOWN   = 2'b10
   } spread_e;

   // Control byte field positions
   localparam int CTL_HIZ   = 0;
   localparam int CTL_SEL4  = 2;
   localparam int CTL_OVR   = 3;
   localparam int CTL_SELLO = 4;

   function automatic fcode_t ctl_code(input logic [7:0] c);
      return {c[CTL_SEL4], c[CTL_SELLO+3:CTL_SELLO]};
   endfunction

   function automatic spread_e spread_of(input fcode_t c);
      spread_e s;
      casez (c)
         5'b011??: s = SPREAD_CENTER;
         5'b111??: s = SPREAD_DOWN;
         5'b00001,
         5'b10011,
         5'b10101: s = SPREAD_DOWN;
         default:  s = SPREAD_OFF;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/sfs_powerup_timer.sv
module sfs_powerup_timer #(
   parameter int POWERUP_CYCLES = 400000
) (
   input  logic clk,
   input  logic rst_n,
   output logic capture_o,
   output logic done_o
);
   localparam int CNT_W = $clog2(POWERUP_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(POWERUP_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign capture_o = !done_q && (cnt_q == LAST);
   assign done_o    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (capture_o) done_q <= 1'b1;
         else           cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sfs_strap_capture.sv
module sfs_strap_capture #(
   parameter int WIDTH       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pad_i,
   input  logic             capture_i,
   output logic [WIDTH-1:0] strap_o
);
   logic [WIDTH-1:0] synced;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced = pad_i;
      end else begin : g_sync
         logic [WIDTH-1:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= pad_i;
               for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign synced = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         strap_o <= '0;
      else if (capture_i) strap_o <= synced;
   end
endmodule

// File: rtl/sfs_code_select.sv
module sfs_code_select
   import sfs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        valid_i,
   input  fcode_t      strap_code_i,
   input  logic [7:0]  ctl_i,
   output fcode_t      code_o,
   output spread_e     spread_o,
   output logic        retune_o
);
   fcode_t nxt_code;

   always_comb begin
      nxt_code = ctl_i[CTL_OVR] ? ctl_code(ctl_i) : strap_code_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o   <= '0;
         spread_o <= SPREAD_OFF;
         retune_o <= 1'b0;
      end else begin
         retune_o <= valid_i && (nxt_code != code_o);
         if (valid_i) begin
            code_o   <= nxt_code;
            spread_o <= spread_of(nxt_code);
         end
      end
   end
endmodule

// File: rtl/strap_freq_select.sv
module strap_freq_select
   import sfs_pkg::*;
#(
   parameter int POWERUP_CYCLES = 400000,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] strap_pad_i,
   input  logic [7:0] ctl_i,
   output logic       pad_oe_o,
   output logic       straps_valid_o,
   output logic [4:0] freq_code_o,
   output logic [1:0] spread_o,
   output logic       sio_24m_o,
   output logic       test_hiz_o,
   output logic       retune_o
);
   generate
      if (POWERUP_CYCLES < SYNC_STAGES + 2) begin : g_bad_delay
         $error("POWERUP_CYCLES must exceed SYNC_STAGES + 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic                capture;
   logic                done;
   logic [STRAP_W-1:0]  strap_q;
   fcode_t              code;
   spread_e             spread;

   sfs_powerup_timer #(.POWERUP_CYCLES(POWERUP_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_o (capture),
      .done_o    (done)
   );

   sfs_strap_capture #(.WIDTH(STRAP_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .pad_i     (strap_pad_i),
      .capture_i (capture),
      .strap_o   (strap_q)
   );

   sfs_code_select u_select (
      .clk          (clk),
      .rst_n        (rst_n),
      .valid_i      (done),
      .strap_code_i (strap_q[CODE_W-1:0]),
      .ctl_i        (ctl_i),
      .code_o       (code),
      .spread_o     (spread),
      .retune_o     (retune_o)
   );

   assign test_hiz_o     = ctl_i[CTL_HIZ];
   assign pad_oe_o       = done && !ctl_i[CTL_HIZ];
   assign straps_valid_o = done;
   assign freq_code_o    = code;
   assign spread_o       = spread;
   assign sio_24m_o      = strap_q[CODE_W];
endmodule

// File: rtl/strap_freq_select_chk.sv
module strap_freq_select_chk #(
   parameter int POWERUP_CYCLES = 400000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pad_oe_o,
   input logic       straps_valid_o,
   input logic [4:0] freq_code_o,
   input logic [1:0] spread_o,
   input logic       sio_24m_o,
   input logic       test_hiz_o,
   input logic       retune_o
);
   localparam int CW = $clog2(POWERUP_CYCLES + 1);
   logic [CW-1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != CW'(POWERUP_CYCLES)) since_rst <= since_rst + 1'b1;
   end

   a_r2_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < CW'(POWERUP_CYCLES)) |-> !straps_valid_o);
   a_r2_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      straps_valid_o |=> straps_valid_o);
   a_r2_oe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe_o |-> straps_valid_o);
   a_r3_sio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (straps_valid_o && $past(straps_valid_o)) |-> $stable(sio_24m_o));
   a_r6_center_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_code_o[4:2] == 3'b011) |-> (spread_o == 2'b01));
   a_r7_down_top: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_code_o[4:2] == 3'b111) |-> (spread_o == 2'b10));
   a_r8_hiz_blocks_oe: assert property (@(posedge clk) disable iff (!rst_n)
      test_hiz_o |-> !pad_oe_o);
   a_r9_change_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_code_o != $past(freq_code_o)) |-> retune_o);
   a_r9_pulse_has_change: assert property (@(posedge clk) disable iff (!rst_n)
      retune_o |-> (freq_code_o != $past(freq_code_o)));
endmodule

bind strap_freq_select strap_freq_select_chk #(.POWERUP_CYCLES(POWERUP_CYCLES)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pad_oe_o       (pad_oe_o),
   .straps_valid_o (straps_valid_o),
   .freq_code_o    (freq_code_o),
   .spread_o       (spread_o),
   .sio_24m_o      (sio_24m_o),
   .test_hiz_o     (test_hiz_o),
   .retune_o       (retune_o)
);

// File: tb/test_strap_freq_select.sv
`timescale 1ns/1ps
module test_strap_freq_select;
   localparam int TC = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] strap_pad_i = '0;
   logic [7:0] ctl_i = '0;
   logic       pad_oe_o, straps_valid_o, sio_24m_o, test_hiz_o, retune_o;
   logic [4:0] freq_code_o;
   logic [1:0] spread_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [4:0] last_code;

   always #2.5 clk = ~clk;

   strap_freq_select #(.POWERUP_CYCLES(TC), .SYNC_STAGES(2)) i_strap_freq_select (
      .clk(clk), .rst_n(rst_n), .strap_pad_i(strap_pad_i), .ctl_i(ctl_i),
      .pad_oe_o(pad_oe_o), .straps_valid_o(straps_valid_o), .freq_code_o(freq_code_o),
      .spread_o(spread_o), .sio_24m_o(sio_24m_o), .test_hiz_o(test_hiz_o),
      .retune_o(retune_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_spread(input logic [4:0] c);
      if (c >= 5'd12 && c <= 5'd15) return 2'b01;
      if (c == 5'd1 || c == 5'd19 || c == 5'd21 || c >= 5'd28) return 2'b10;
      return 2'b00;
   endfunction

   function automatic logic [7:0] ovr_byte(input logic [4:0] c);
      return {c[3:0], 1'b1, c[4], 2'b00};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // R1, R2, R4, R5: reset state, power-up interval and strap capture
   task automatic t_powerup(input logic [5:0] straps);
      rst_n = 1'b0;
      ctl_i = '0;
      strap_pad_i = straps;
      repeat (3) @(negedge clk);
      chk("R1 pad_oe in reset", pad_oe_o, 0);
      chk("R1 valid in reset", straps_valid_o, 0);
      chk("R1 code in reset", freq_code_o, 0);
      chk("R1 spread in reset", spread_o, 0);
      chk("R1 retune in reset", retune_o, 0);
      rst_n = 1'b1;
      repeat (TC - 1) step();
      chk("R2 pad_oe before interval end", pad_oe_o, 0);
      chk("R2 valid before interval end", straps_valid_o, 0);
      step();
      chk("R2 valid at interval end", straps_valid_o, 1);
      chk("R2 pad_oe at interval end", pad_oe_o, 1);
      chk("R4 sio strap", sio_24m_o, straps[5]);
      step();
      chk("R5 strapped code", freq_code_o, straps[4:0]);
      chk("R7 strapped spread", spread_o, exp_spread(straps[4:0]));
      chk("R9 pulse on first code", retune_o, straps[4:0] != 5'd0);
      step();
      chk("R9 pulse one cycle", retune_o, 0);
      last_code = straps[4:0];
   endtask

   // R3: pads move after capture
   task automatic t_strap_ignored();
      logic [4:0] c0;
      logic       s0;
      c0 = freq_code_o;
      s0 = sio_24m_o;
      strap_pad_i = ~strap_pad_i;
      repeat (6) step();
      chk("R3 code frozen", freq_code_o, c0);
      chk("R3 sio frozen", sio_24m_o, s0);
      chk("R3 no retune", retune_o, 0);
   endtask

   // R5, R6, R7, R9: override codes
   task automatic t_override(input logic [4:0] c);
      ctl_i = ovr_byte(c);
      step();
      chk("R5 override code", freq_code_o, c);
      if (c >= 5'd12 && c <= 5'd15) chk("R6 center spread", spread_o, exp_spread(c));
      else                          chk("R7 spread decode", spread_o, exp_spread(c));
      chk("R9 retune on change", retune_o, c != last_code);
      last_code = c;
   endtask

   // R8: test hi-Z gating
   task automatic t_hiz();
      logic [7:0] keep;
      keep = ctl_i;
      ctl_i = keep | 8'h01;
      #1;
      chk("R8 hiz flag", test_hiz_o, 1);
      chk("R8 pad_oe off", pad_oe_o, 0);
      step();
      chk("R8 pad_oe stays off", pad_oe_o, 0);
      ctl_i = keep;
      #1;
      chk("R8 pad_oe back", pad_oe_o, 1);
      chk("R8 hiz clear", test_hiz_o, 0);
   endtask

   // R5: dropping override returns to the strapped code
   task automatic t_back_to_strap(input logic [4:0] strapped);
      ctl_i = '0;
      step();
      chk("R5 strap code after override", freq_code_o, strapped);
      chk("R9 retune back", retune_o, strapped != last_code);
      last_code = strapped;
      step();
      chk("R9 no repeat pulse", retune_o, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_powerup(6'b1_10110);
      t_strap_ignored();
      t_override(5'b01100);
      t_override(5'b01111);
      t_override(5'b01111);
      t_override(5'b00001);
      t_override(5'b10011);
      t_override(5'b10101);
      t_override(5'b11100);
      t_override(5'b11111);
      t_override(5'b00000);
      t_override(5'b10100);
      t_override(5'b01011);
      t_hiz();
      t_back_to_strap(5'b10110);
      t_powerup(6'b0_01101);
      t_hiz();
      t_powerup(6'b0_00000);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule